// File: doc/BRIEF.md
# Dynamic Interrupt Priority Selector

This block picks, in one combinational pass, the single interrupt line that should be serviced next for one interrupt class. It looks at up to three banks of 32 lines. For each line it receives a pending bit, a mask bit, a class bit and a priority value. It then reports the code of the winning line, together with a flag that says whether any line qualified at all.

A controller normally uses two copies of the selector:
- one copy with the class request tied low, for the normal class;
- one copy with the class request tied high, for the fast class.

The selector holds no state. The registers that hold pending, mask, class and priority bits live outside it, and so does any edge detection on the input lines.

A smaller priority number is more urgent. When several lines share the best number, the line with the larger index wins. The comparison is built as a balanced tree of pairwise (priority, index) contests. This keeps the logic depth proportional to the log of the line count.

Top module: `prio_pick`

## Requirements
- R1: A line is a candidate only when all of the following hold: its pending bit is 1, its mask bit is 0, and its class bit equals `want_fast_i` (class bit 1 means fast, 0 means normal).
- R2: Among candidates, the one with the numerically smallest priority field wins; priority 0 is the most urgent.
- R3: When several candidates share the smallest priority value, the candidate with the highest line index wins.
- R4: `win_o` carries 32 × bank + bit position, where line k of the flat vectors is bank k/32, bit k%32.
- R5: With no candidate, `win_o` is 0 and `any_o` is 0.
- R6: `any_o` is 1 exactly when at least one candidate exists for the requested class.
- R7: Lines in banks numbered `BANKS` and above (line index ≥ 32 × `BANKS`) are never candidates, whatever their inputs.
- R8: The same pending, mask and priority inputs give independent winners for the normal and the fast class, selected only by `want_fast_i`.
- R9: The priority field of line k occupies bits [k×PRIO_W +: PRIO_W] of `prio_i`, and all PRIO_W bits take part in the comparison: 6 bits by default, 5 bits in a single-bank setup. The largest value 2^PRIO_W−1 still wins when it is the only candidate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pend_i | input | 32×MAX_BANKS | Pending bit per line |
| mask_i | input | 32×MAX_BANKS | Mask bit per line, 1 blocks the line |
| fast_i | input | 32×MAX_BANKS | Class bit per line, 1 for fast |
| prio_i | input | 32×MAX_BANKS×PRIO_W | Packed priority fields, line k at [k×PRIO_W +: PRIO_W] |
| want_fast_i | input | 1 | Class being arbitrated, 1 for fast |
| win_o | output | clog2(32×MAX_BANKS) | Code of the winning line, 0 if none |
| any_o | output | 1 | At least one candidate exists |

## Verification
The checker assumes that every input is driven to a known value whenever the outputs are examined. It also assumes that any priority field in the packed vector is legal, since all encodings of PRIO_W bits are meaningful.

The bench changes inputs only just after a rising clock edge and reads outputs at the following falling edge. The purely combinational result has therefore settled before any check or assertion inspects it.

Inputs for unused banks are driven with active-looking values on purpose. This shows that the bank limit, and not the stimulus, is what removes those lines.

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int BANKS     = 3,
  parameter int PRIO_W    = 6,
  parameter int MAX_BANKS = 3,
  localparam int LINES    = 32 * MAX_BANKS,
  localparam int IDX_W    = $clog2(LINES)
) (
  input  logic [LINES-1:0]        pend_i,
  input  logic [LINES-1:0]        mask_i,
  input  logic [LINES-1:0]        fast_i,
  input  logic [LINES*PRIO_W-1:0] prio_i,
  input  logic                    want_fast_i,
  output logic [IDX_W-1:0]        win_o,
  output logic                    any_o
);
  localparam int LEAVES = 1 << IDX_W;
  localparam int ACTIVE = 32 * BANKS;

  // heap-ordered contest tree: node k has children 2k (lower indices) and 2k+1
  logic              nv [1:2*LEAVES-1];
  logic [PRIO_W-1:0] np [1:2*LEAVES-1];
  logic [IDX_W-1:0]  ni [1:2*LEAVES-1];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < LINES) begin : g_real
      localparam bit LIVE = (j < ACTIVE);
      assign nv[LEAVES+j] = pend_i[j] & ~mask_i[j] & (fast_i[j] ~^ want_fast_i) & LIVE;
      assign np[LEAVES+j] = prio_i[j*PRIO_W +: PRIO_W];
    end else begin : g_pad
      assign nv[LEAVES+j] = 1'b0;
      assign np[LEAVES+j] = '0;
    end
    assign ni[LEAVES+j] = IDX_W'(j);
  end

  for (genvar k = 1; k < LEAVES; k++) begin : g_node
    logic take_hi;
    assign take_hi = nv[2*k+1] & (~nv[2*k] | (np[2*k+1] <= np[2*k]));
    assign nv[k]   = nv[2*k] | nv[2*k+1];
    assign np[k]   = take_hi ? np[2*k+1] : np[2*k];
    assign ni[k]   = take_hi ? ni[2*k+1] : ni[2*k];
  end

  assign any_o = nv[1];
  assign win_o = nv[1] ? ni[1] : '0;
endmodule

// File: rtl/prio_pick_chk.sv
module prio_pick_chk #(
  parameter int BANKS     = 3,
  parameter int PRIO_W    = 6,
  parameter int MAX_BANKS = 3,
  localparam int LINES    = 32 * MAX_BANKS,
  localparam int IDX_W    = $clog2(LINES)
) (
  input logic [LINES-1:0]        pend_i,
  input logic [LINES-1:0]        mask_i,
  input logic [LINES-1:0]        fast_i,
  input logic [LINES*PRIO_W-1:0] prio_i,
  input logic                    want_fast_i,
  input logic [IDX_W-1:0]        win_o,
  input logic                    any_o
);
  logic [LINES-1:0] cand;

  always_comb begin
    for (int j = 0; j < LINES; j++)
      cand[j] = pend_i[j] & ~mask_i[j] & (fast_i[j] == want_fast_i) & (j < 32 * BANKS);
  end

  always_comb begin
    if (!$isunknown({pend_i, mask_i, fast_i, prio_i, want_fast_i, win_o, any_o})) begin
      if (!any_o) begin
        p_idle_code_r5: assert (win_o == '0) else $error("R5: code %0d with no candidate", win_o);
      end
      p_any_match_r6: assert (any_o == (|cand)) else $error("R6: any flag disagrees");
      if (any_o) begin
        p_bank_limit_r7: assert (int'(win_o) < 32 * BANKS) else $error("R7: winner %0d beyond banks", win_o);
        if (int'(win_o) < LINES) begin
          p_win_qualified_r1: assert (cand[win_o]) else $error("R1: winner %0d not a candidate", win_o);
          for (int j = 0; j < LINES; j++) begin
            if (cand[j]) begin
              p_best_prio_r2: assert (prio_i[j*PRIO_W +: PRIO_W] >= prio_i[int'(win_o)*PRIO_W +: PRIO_W])
                else $error("R2: line %0d more urgent than winner %0d", j, win_o);
              if (prio_i[j*PRIO_W +: PRIO_W] == prio_i[int'(win_o)*PRIO_W +: PRIO_W]) begin
                p_tie_high_r3: assert (j <= int'(win_o))
                  else $error("R3: tie lost to lower index %0d over %0d", win_o, j);
              end
            end
          end
        end
      end
    end
  end
endmodule

bind prio_pick prio_pick_chk #(.BANKS(BANKS), .PRIO_W(PRIO_W), .MAX_BANKS(MAX_BANKS)) u_chk (
  .pend_i(pend_i), .mask_i(mask_i), .fast_i(fast_i), .prio_i(prio_i),
  .want_fast_i(want_fast_i), .win_o(win_o), .any_o(any_o)
);

// File: tb/prio_pick_bench.sv
module prio_pick_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 96;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [LINES-1:0]   pend = '0, mask = '0, fast = '0;
  logic [LINES*6-1:0] prio6 = '0;
  logic [LINES*5-1:0] prio5 = '0;
  logic               want = 1'b0;
  logic [6:0]         win_a, win_b;
  logic               any_a, any_b;

  int checks = 0;
  int errors = 0;

  prio_pick u_prio_pick (
    .pend_i(pend), .mask_i(mask), .fast_i(fast), .prio_i(prio6),
    .want_fast_i(want), .win_o(win_a), .any_o(any_a)
  );

  prio_pick #(.BANKS(1), .PRIO_W(5), .MAX_BANKS(3)) u_prio_pick_one (
    .pend_i(pend), .mask_i(mask), .fast_i(fast), .prio_i(prio5),
    .want_fast_i(want), .win_o(win_b), .any_o(any_b)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    @(posedge clk);
    pend = '0; mask = '0; fast = '0; prio6 = '0; prio5 = '0; want = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_idle();
    clear_all(); settle();
    check("R5 idle any", int'(any_a), 0);
    check("R5 idle code", int'(win_a), 0);
  endtask

  task automatic t_candidate();
    clear_all(); pend[10] = 1; mask[10] = 1; settle();
    check("R1 masked line", int'(any_a), 0);
    @(posedge clk); mask[10] = 0; settle();
    check("R1 unmasked line", int'(win_a), 10);
    @(posedge clk); fast[10] = 1; settle();
    check("R1 wrong class", int'(any_a), 0);
    check("R5 wrong class code", int'(win_a), 0);
    @(posedge clk); want = 1; settle();
    check("R1 matching class", int'(win_a), 10);
  endtask

  task automatic t_priority();
    clear_all();
    pend[5] = 1; prio6[5*6 +: 6] = 7;
    pend[40] = 1; prio6[40*6 +: 6] = 3;
    pend[80] = 1; prio6[80*6 +: 6] = 9;
    settle();
    check("R2 smallest wins", int'(win_a), 40);
    @(posedge clk); prio6[80*6 +: 6] = 0; settle();
    check("R2 priority zero", int'(win_a), 80);
  endtask

  task automatic t_tie();
    clear_all();
    pend[3] = 1; pend[50] = 1; pend[70] = 1;
    prio6[3*6 +: 6] = 4; prio6[50*6 +: 6] = 4; prio6[70*6 +: 6] = 4;
    settle();
    check("R3 tie highest index", int'(win_a), 70);
    @(posedge clk); pend = '1; prio6 = '0; settle();
    check("R3 all lines tie", int'(win_a), 95);
    @(posedge clk); prio6[95*6 +: 6] = 1; settle();
    check("R3 next highest", int'(win_a), 94);
  endtask

  task automatic t_code();
    clear_all(); pend[33] = 1; settle();
    check("R4 bank1 bit1", int'(win_a), 33);
    @(posedge clk); pend = '0; pend[81] = 1; settle();
    check("R4 bank2 bit17", int'(win_a), 81);
    @(posedge clk); pend = '0; pend[0] = 1; settle();
    check("R4 line zero any", int'(any_a), 1);
    check("R4 line zero code", int'(win_a), 0);
  endtask

  task automatic t_class();
    clear_all();
    pend[20] = 1; prio6[20*6 +: 6] = 1;
    pend[60] = 1; fast[60] = 1; prio6[60*6 +: 6] = 5;
    settle();
    check("R8 normal class", int'(win_a), 20);
    @(posedge clk); want = 1; settle();
    check("R8 fast class", int'(win_a), 60);
  endtask

  task automatic t_any();
    clear_all(); pend[77] = 1; pend[12] = 1; mask[77] = 1; settle();
    check("R6 one live", int'(any_a), 1);
    @(posedge clk); mask[12] = 1; settle();
    check("R6 all masked", int'(any_a), 0);
  endtask

  task automatic t_bank_limit();
    clear_all();
    pend[40] = 1; prio5[40*5 +: 5] = 0;
    pend[5] = 1; prio5[5*5 +: 5] = 10;
    settle();
    check("R7 upper bank ignored", int'(win_b), 5);
    @(posedge clk); pend[5] = 0; pend[90] = 1; settle();
    check("R7 no live bank any", int'(any_b), 0);
    check("R7 no live bank code", int'(win_b), 0);
  endtask

  task automatic t_width();
    clear_all(); pend[2] = 1; pend[3] = 1;
    prio6[2*6 +: 6] = 31; prio6[3*6 +: 6] = 32; settle();
    check("R9 sixth bit counts", int'(win_a), 2);
    @(posedge clk); pend[2] = 0; prio6[3*6 +: 6] = 63; settle();
    check("R9 max value alone", int'(win_a), 3);
    @(posedge clk); pend = '0; pend[0] = 1; pend[1] = 1;
    prio5[0 +: 5] = 30; prio5[5 +: 5] = 31; settle();
    check("R9 five bit compare", int'(win_b), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_idle();
    t_candidate();
    t_priority();
    t_tie();
    t_code();
    t_class();
    t_any();
    t_bank_limit();
    t_width();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule